// File: doc/BRIEF.md
# Word Shift and Rotate Unit

This block shifts or rotates a 32-bit data word inside a small integer datapath. It offers logical left, logical right and arithmetic right shifts plus left and right rotates. The count comes either from a register operand or from a short immediate field. Register-sourced shifts look at six count bits, so counts from 32 to 63 are legal and must clear the word, or fill it with copies of the sign bit.

Operands enter through a valid/ready stream and the result leaves through a second valid/ready stream after one register stage. An operand is taken on any clock edge where `in_valid` and `in_ready` are both high. The result then stays on `result` with `out_valid` high until the consumer raises `out_ready`. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so back-pressure reaches the producer without delay. Nothing is dropped and nothing is duplicated.

Top module: `shf_unit`

## Requirements
- R1: Operation code 0 (shift left) with `imm_sel`=0 shifts `data_in` left by `amt_reg[5:0]` and fills the vacated low bits with zeros.
- R2: Operation code 1 (logical shift right) with `imm_sel`=0 shifts right by `amt_reg[5:0]` and fills the vacated high bits with zeros.
- R3: Operation code 2 (arithmetic shift right) with `imm_sel`=0 shifts right by `amt_reg[5:0]` and fills the vacated high bits with copies of `data_in[31]`.
- R4: For a register count `amt_reg[5:0]` from 32 to 63, codes 0 and 1 give 0, and code 2 gives 0xFFFFFFFF when `data_in[31]` is 1 and 0 when it is 0. Bits above bit 5 of `amt_reg` never affect a result.
- R5: With `imm_sel`=1, every shift and rotate takes its count from the 5-bit `amt_imm`, and `amt_reg` has no effect.
- R6: Operation code 3 (rotate left) and code 4 (rotate right) with `imm_sel`=0 rotate by `amt_reg[4:0]` only. Bit 5 of the amount has no effect on a rotate.
- R7: A rotate right by n gives the same word as a rotate left by (32 - n) mod 32, for every n from 0 to 31.
- R8: A count of 0 returns `data_in` unchanged for every operation.
- R9: Operation codes 5, 6 and 7 return `data_in` unchanged.
- R10: An operand accepted at a clock edge appears on `result` with `out_valid` high after that edge. While `out_valid` is high and `out_ready` is low, `result` and `out_valid` hold, and `in_ready` is low.
- R11: After reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand stream valid |
| in_ready | output | 1 | Operand stream ready |
| op | input | 3 | Operation code: 0 shl, 1 shr, 2 shrs, 3 rotl, 4 rotr, 5-7 pass |
| data_in | input | 32 | Word to shift or rotate |
| amt_reg | input | 32 | Register count operand, low six bits used |
| amt_imm | input | 5 | Immediate count field |
| imm_sel | input | 1 | 1 selects `amt_imm` as the count |
| out_valid | output | 1 | Result stream valid |
| out_ready | input | 1 | Result stream ready |
| result | output | 32 | Shifted or rotated word |

## Verification
The bench builds the unit with its default 32-bit word and 32-bit amount register. With these defaults the 5-bit immediate and the 6-bit register count span every count from 0 to 63, so directed vectors can sweep each count once, including the flush band from 32 to 63. The rotate equivalence can also be compared exhaustively. Random amounts leave the upper bits of `amt_reg` set, which tests that only the low six bits are decoded. A stall sequence holds `out_ready` low to show the output register holding its value while a second operand waits.

// File: rtl/shf_pkg.sv
package shf_pkg;

  typedef enum logic [2:0] {
    OP_SHL  = 3'd0,
    OP_SHR  = 3'd1,
    OP_SHRS = 3'd2,
    OP_ROTL = 3'd3,
    OP_ROTR = 3'd4
  } shf_op_e;

  function automatic logic op_is_shift(input logic [2:0] code);
    return (code == OP_SHL) || (code == OP_SHR) || (code == OP_SHRS);
  endfunction

  function automatic logic op_is_rot(input logic [2:0] code);
    return (code == OP_ROTL) || (code == OP_ROTR);
  endfunction

endpackage

// File: rtl/shf_amount_sel.sv
module shf_amount_sel
  import shf_pkg::*;
#(
  parameter int LW = 5
) (
  input  logic [2:0]    op,
  input  logic [LW:0]   amt_low,
  input  logic [LW-1:0] amt_imm,
  input  logic          imm_sel,
  output logic [LW-1:0] cnt,
  output logic          flush
);

  logic [LW:0] wide_cnt;

  // Register shifts see one extra count bit; immediates are zero-extended.
  always_comb begin
    wide_cnt = imm_sel ? {1'b0, amt_imm} : amt_low;
    cnt      = '0;
    flush    = 1'b0;
    if (op_is_shift(op)) begin
      cnt   = wide_cnt[LW-1:0];
      flush = wide_cnt[LW];
    end else if (op_is_rot(op)) begin
      cnt   = imm_sel ? amt_imm : amt_low[LW-1:0];
    end
  end

endmodule

// File: rtl/shf_core.sv
module shf_core #(
  parameter int W  = 32,
  parameter int LW = 5
) (
  input  logic [W-1:0]  din,
  input  logic [LW-1:0] cnt,
  input  logic          go_left,
  input  logic          rotate,
  input  logic          fill,
  output logic [W-1:0]  dout
);

  logic [W-1:0] flip_in;
  logic [W-1:0] stg [0:LW];

  // Left operations run on the mirrored word through the same right network.
  for (genvar i = 0; i < W; i++) begin : g_flip_in
    assign flip_in[i] = go_left ? din[W-1-i] : din[i];
  end

  assign stg[0] = flip_in;

  for (genvar k = 0; k < LW; k++) begin : g_stage
    localparam int S = 1 << k;
    logic [S-1:0] top_bits;
    assign top_bits   = rotate ? stg[k][S-1:0] : {S{fill}};
    assign stg[k + 1] = cnt[k] ? {top_bits, stg[k][W-1:S]} : stg[k];
  end

  for (genvar i = 0; i < W; i++) begin : g_flip_out
    assign dout[i] = go_left ? stg[LW][W-1-i] : stg[LW][i];
  end

endmodule

// File: rtl/shf_out_stage.sv
module shf_out_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  // R10
  hold_while_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R10
  ready_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

endmodule

// File: rtl/shf_unit.sv
module shf_unit
  import shf_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = 32,
  parameter int LW    = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2:0]    op,
  input  logic [W-1:0]  data_in,
  input  logic [AMT_W-1:0] amt_reg,
  input  logic [LW-1:0] amt_imm,
  input  logic          imm_sel,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  result
);

  logic [LW-1:0] cnt;
  logic          flush;
  logic          go_left;
  logic          rotate;
  logic          fill;
  logic          known_op;
  logic [W-1:0]  core_out;
  logic [W-1:0]  next_word;
  logic          unused_amt_hi;

  assign unused_amt_hi = ^amt_reg[AMT_W-1:LW+1];

  shf_amount_sel #(.LW(LW)) amount_i (
    .op      (op),
    .amt_low (amt_reg[LW:0]),
    .amt_imm (amt_imm),
    .imm_sel (imm_sel),
    .cnt     (cnt),
    .flush   (flush)
  );

  assign go_left  = (op == OP_SHL) || (op == OP_ROTL);
  assign rotate   = op_is_rot(op);
  assign fill     = (op == OP_SHRS) && data_in[W-1];
  assign known_op = op_is_shift(op) || op_is_rot(op);

  shf_core #(.W(W), .LW(LW)) core_i (
    .din     (data_in),
    .cnt     (cnt),
    .go_left (go_left),
    .rotate  (rotate),
    .fill    (fill),
    .dout    (core_out)
  );

  always_comb begin
    if (!known_op)  next_word = data_in;
    else if (flush) next_word = {W{fill}};
    else            next_word = core_out;
  end

  shf_out_stage #(.W(W)) stage_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (next_word),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (result)
  );

  // R8
  zero_count_passes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !flush && cnt == '0) |=> (result == $past(data_in)));

  // R4
  flush_left_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && op == OP_SHL && !imm_sel && amt_reg[LW])
      |=> (result == '0));

  // R6
  rotate_keeps_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && op_is_rot(op))
      |=> ($countones(result) == $countones($past(data_in))));

  // R10
  accept_gives_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

endmodule

// File: tb/shf_unit_tb_top.sv
module shf_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  op = '0;
  logic [31:0] data_in = '0;
  logic [31:0] amt_reg = '0;
  logic [4:0]  amt_imm = '0;
  logic        imm_sel = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] result;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  shf_unit dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .op        (op),
    .data_in   (data_in),
    .amt_reg   (amt_reg),
    .amt_imm   (amt_imm),
    .imm_sel   (imm_sel),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .result    (result)
  );

  function automatic logic [31:0] rol(input logic [31:0] d, input int n);
    if (n == 0) return d;
    return (d << n) | (d >> (32 - n));
  endfunction

  function automatic logic [31:0] model(input logic [2:0] o, input logic [31:0] d,
                                        input logic [31:0] a, input logic [4:0] im,
                                        input logic sel);
    int n6 = sel ? int'(im) : int'(a[5:0]);
    int n5 = sel ? int'(im) : int'(a[4:0]);
    case (o)
      3'd0: return (n6 >= 32) ? 32'h0 : (d << n6);
      3'd1: return (n6 >= 32) ? 32'h0 : (d >> n6);
      3'd2: begin
        if (n6 >= 32) return {32{d[31]}};
        return (d >> n6) | ((n6 == 0 || !d[31]) ? 32'h0 : ~(32'hFFFFFFFF >> n6));
      end
      3'd3: return rol(d, n5);
      3'd4: return rol(d, (32 - n5) % 32);
      default: return d;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [2:0] o, input logic [31:0] d, input logic [31:0] a,
                       input logic [4:0] im, input logic sel, output logic [31:0] got);
    @(negedge clk);
    op = o; data_in = d; amt_reg = a; amt_imm = im; imm_sel = sel;
    in_valid = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    if (out_valid !== 1'b1) begin
      vectors++; miscompares++;
      $display("FAIL R10: out_valid got %b expected 1", out_valid);
    end
    got = result;
  endtask

  task automatic run(input string req, input logic [2:0] o, input logic [31:0] d,
                     input logic [31:0] a, input logic [4:0] im, input logic sel);
    logic [31:0] got;
    apply(o, d, a, im, sel, got);
    check(req, got, model(o, d, a, im, sel));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL watchdog: got %0d cycles expected at most %0d", cycles, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [31:0] r_right, r_left, first, second, w;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11
    check("R11 out_valid", {31'b0, out_valid}, 32'h0);
    check("R11 in_ready", {31'b0, in_ready}, 32'h1);
    rst_n = 1'b1;

    // R1 R2 R3 directed register shifts in the low band
    run("R1", 3'd0, 32'h8000_0001, 32'd4, 5'd0, 1'b0);
    run("R2", 3'd1, 32'h8000_00F0, 32'd4, 5'd0, 1'b0);
    run("R3", 3'd2, 32'h8000_00F0, 32'd4, 5'd0, 1'b0);
    run("R3", 3'd2, 32'h4000_0000, 32'd31, 5'd0, 1'b0);
    check("R3 literal", model(3'd2, 32'h8000_0000, 32'd31, 5'd0, 1'b0), 32'hFFFF_FFFF);
    // R4 every count 32..63, upper amount bits set
    for (int n = 32; n < 64; n++) begin
      run("R4 shl", 3'd0, 32'hDEAD_BEEF, 32'hABCD_0000 | n, 5'd0, 1'b0);
      run("R4 shr", 3'd1, 32'hDEAD_BEEF, 32'hABCD_0000 | n, 5'd0, 1'b0);
      run("R4 shrs neg", 3'd2, 32'hDEAD_BEEF, 32'h0000_0000 | n, 5'd0, 1'b0);
      run("R4 shrs pos", 3'd2, 32'h5EAD_BEEF, 32'hFFFF_FFC0 | n, 5'd0, 1'b0);
    end
    apply(3'd0, 32'hFFFF_FFFF, 32'd40, 5'd0, 1'b0, w);
    check("R4 shl literal", w, 32'h0);
    apply(3'd2, 32'h8000_0000, 32'd63, 5'd0, 1'b0, w);
    check("R4 shrs literal", w, 32'hFFFF_FFFF);
    // R5 immediate forms ignore amt_reg
    for (int n = 0; n < 32; n++) begin
      for (int o = 0; o < 5; o++) begin
        run("R5", 3'(o), 32'hC3A5_5A3C, 32'hFFFF_FFFF, 5'(n), 1'b1);
      end
    end
    apply(3'd0, 32'h0000_0001, 32'd63, 5'd3, 1'b1, w);
    check("R5 literal", w, 32'h0000_0008);
    // R6 rotates ignore amount bit 5
    apply(3'd3, 32'h8000_0001, 32'd33, 5'd0, 1'b0, w);
    check("R6 rotl 33", w, 32'h0000_0003);
    apply(3'd4, 32'h8000_0001, 32'd33, 5'd0, 1'b0, w);
    check("R6 rotr 33", w, 32'hC000_0000);
    // R7 rotate equivalence across all counts
    for (int n = 0; n < 32; n++) begin
      apply(3'd4, 32'h1234_5678, 32'd0, 5'(n), 1'b1, r_right);
      apply(3'd3, 32'h1234_5678, 32'd0, 5'((32 - n) % 32), 1'b1, r_left);
      check("R7", r_right, r_left);
    end
    // R8 zero count on every op, register and immediate
    for (int o = 0; o < 5; o++) begin
      apply(3'(o), 32'h9ABC_DEF0, 32'hFFFF_FFC0, 5'd0, 1'b0, w);
      check("R8 reg", w, 32'h9ABC_DEF0);
      apply(3'(o), 32'h9ABC_DEF0, 32'h0, 5'd0, 1'b1, w);
      check("R8 imm", w, 32'h9ABC_DEF0);
    end
    // R9 unused codes
    for (int o = 5; o < 8; o++) begin
      apply(3'(o), 32'h0F0F_1234, 32'd7, 5'd7, 1'b0, w);
      check("R9", w, 32'h0F0F_1234);
    end
    // R10 stall: output holds, second operand waits
    @(negedge clk);
    out_ready = 1'b0;
    op = 3'd0; data_in = 32'h0000_00FF; amt_reg = 32'd8; imm_sel = 1'b0;
    in_valid = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    first = result;
    check("R10 first", first, 32'h0000_FF00);
    check("R10 in_ready low", {31'b0, in_ready}, 32'h0);
    op = 3'd1; data_in = 32'hF000_0000; amt_reg = 32'd4;
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 held data", result, 32'h0000_FF00);
    check("R10 held valid", {31'b0, out_valid}, 32'h1);
    out_ready = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    second = result;
    check("R10 second", second, 32'h0F00_0000);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      run("R1-random", 3'($urandom_range(0, 7)), $urandom(), $urandom(),
          5'($urandom()), 1'($urandom()));
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule